// File: doc/BRIEF.md
# Receive Pattern Alarm and Sync Monitor

This block sits on the receive side of a bit-error-rate tester. Each received bit arrives as a serial data bit together with a per-bit error flag from the upstream pattern comparator, and a bit-valid enable qualifies both. The block watches runs of identical bits and raises an all-ones or an all-zeros alarm. It also tracks whether the receiver is locked to the test pattern. Lock is declared by a pulse from the pattern search logic. Lock is lost when errors become too dense or when an external resync is requested.

The most recent 32 received bits are kept in a shift register. A processor reads this register one byte at a time through a small address decode. The alarm and sync outputs are intended to feed a status register that lives outside this block.

Top module: `rx_pattern_monitor`

## Requirements
- R1: `all_ones` goes high on the cycle after the enabled clock edge that accepts the 32nd consecutive 1, and it stays high while further 1s are accepted.
- R2: `all_ones` goes low on the cycle after the first accepted 0.
- R3: `all_zeros` goes high on the cycle after the enabled clock edge that accepts the 32nd consecutive 0, and it stays high while further 0s are accepted.
- R4: `all_zeros` goes low on the cycle after the first accepted 1.
- R5: After reset the monitor is searching, with `in_sync`=0 and `los`=1. While searching, a high `sync_found` sets `in_sync` (and clears `los`) on the next cycle. `los` stays high for the whole search.
- R6: With `dens_off`=0, while in sync, the accepted bits are grouped into non-overlapping blocks of 64, where the first block starts at acquisition. When 6 errored bits have been accepted within one block, `in_sync` clears on the next cycle. The error count restarts at each block boundary.
- R7: With `dens_off`=1, errored bits never clear `in_sync`.
- R8: A high `resync_req` while in sync clears `in_sync` on the next cycle, regardless of `dens_off`.
- R9: Each accepted bit shifts into bit 0 of a 32-bit pattern register. `rd_data` is a combinational read of that register. Address 0x10 returns bits 31:24, 0x11 returns 23:16, 0x12 returns 15:8 and 0x13 returns 7:0. Any other address reads 0. Reset clears the register.
- R10: Cycles with `bit_en`=0 leave the run alarms, the pattern register and the error-density state unchanged, whatever `rx_bit` and `bit_err` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `rx_bit` and `bit_err` |
| rx_bit | input | 1 | Received data bit |
| bit_err | input | 1 | The current bit mismatched the expected pattern |
| sync_found | input | 1 | Pattern search declares lock |
| resync_req | input | 1 | Forces loss of sync |
| dens_off | input | 1 | 1 disables the error-density loss rule |
| rd_addr | input | 8 | Byte read address |
| rd_data | output | 8 | Pattern register byte at `rd_addr` |
| all_ones | output | 1 | All-ones alarm |
| all_zeros | output | 1 | All-zeros alarm |
| in_sync | output | 1 | Locked to the pattern |
| los | output | 1 | Loss of sync (searching) |

## Verification
The assertions assume that every input is a clean 0 or 1 at each clock edge. They place no restriction on `sync_found`: while locked, this input is simply ignored. The stimulus follows these assumptions. It drives all inputs one step after the rising edge and deliberately pulses `sync_found` while the monitor is already locked. It also toggles `dens_off` in the middle of a block and sweeps `rd_addr` across and beyond the decoded window. The random phase sends long biased runs so that both run alarms set and release, and it sends error bursts dense enough to trip the density rule.

// File: rtl/rx_pattern_monitor.sv
module rx_pattern_monitor #(
  parameter int          RUN_LEN   = 32,
  parameter int          WIN_LEN   = 64,
  parameter int          ERR_LIM   = 6,
  parameter int          PAT_W     = 32,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              bit_err,
  input  logic              sync_found,
  input  logic              resync_req,
  input  logic              dens_off,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              all_ones,
  output logic              all_zeros,
  output logic              in_sync,
  output logic              los
);
  localparam int RUN_W  = $clog2(RUN_LEN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int ERR_W  = $clog2(ERR_LIM + 1);
  localparam int NBYTES = PAT_W / 8;

  logic [RUN_W-1:0] ones_cnt, zeros_cnt;
  logic [PAT_W-1:0] pat;
  logic [WIN_W-1:0] blk_cnt;
  logic [ERR_W-1:0] err_cnt;
  logic [ERR_W:0]   err_sum;
  logic             dens_hit, blk_end;

  // run counters and pattern shift
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_cnt  <= '0;
      zeros_cnt <= '0;
      pat       <= '0;
    end else if (bit_en) begin
      pat <= {pat[PAT_W-2:0], rx_bit};
      if (rx_bit) begin
        zeros_cnt <= '0;
        if (!all_ones) ones_cnt <= ones_cnt + 1'b1;
      end else begin
        ones_cnt <= '0;
        if (!all_zeros) zeros_cnt <= zeros_cnt + 1'b1;
      end
    end
  end

  assign all_ones  = (ones_cnt  == RUN_W'(RUN_LEN));
  assign all_zeros = (zeros_cnt == RUN_W'(RUN_LEN));

  // error-density sync tracking
  assign err_sum  = (ERR_W+1)'(err_cnt) + (ERR_W+1)'(bit_err);
  assign dens_hit = !dens_off && (err_sum >= (ERR_W+1)'(ERR_LIM));
  assign blk_end  = (blk_cnt == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sync <= 1'b0;
      blk_cnt <= '0;
      err_cnt <= '0;
    end else if (!in_sync) begin
      blk_cnt <= '0;
      err_cnt <= '0;
      if (sync_found) in_sync <= 1'b1;
    end else if (resync_req) begin
      in_sync <= 1'b0;
    end else if (bit_en) begin
      if (dens_hit) in_sync <= 1'b0;
      if (dens_hit || blk_end) begin
        blk_cnt <= '0;
        err_cnt <= '0;
      end else begin
        blk_cnt <= blk_cnt + 1'b1;
        err_cnt <= (err_sum >= (ERR_W+1)'(ERR_LIM)) ? ERR_W'(ERR_LIM) : err_sum[ERR_W-1:0];
      end
    end
  end

  assign los = !in_sync;

  // byte read of the pattern register, most significant byte at the base
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NBYTES; i++)
      if (rd_addr == ADDR_W'(BASE_ADDR + i))
        rd_data = pat[PAT_W-1-8*i -: 8];
  end

  AST_ONES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && rx_bit && ones_cnt == RUN_W'(RUN_LEN-1) |=> all_ones); // R1
  AST_ONES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !rx_bit |=> !all_ones); // R2
  AST_ZEROS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !rx_bit && zeros_cnt == RUN_W'(RUN_LEN-1) |=> all_zeros); // R3
  AST_ZEROS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && rx_bit |=> !all_zeros); // R4
  AST_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync && sync_found |=> in_sync); // R5
  AST_DENS_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && dens_off && !resync_req |=> in_sync); // R7
  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && resync_req |=> !in_sync); // R8
  AST_PAT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> pat[0] == $past(rx_bit)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pat) && $stable(ones_cnt) && $stable(zeros_cnt)); // R10
endmodule

// File: tb/tb_rx_pattern_monitor.sv
`timescale 1ns/1ps
module tb_rx_pattern_monitor;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, rx_bit = 0, bit_err = 0, sync_found = 0, resync_req = 0, dens_off = 0;
  logic [7:0] rd_addr = 8'h10;
  logic [7:0] rd_data;
  logic all_ones, all_zeros, in_sync, los;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_pattern_monitor dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .bit_err(bit_err), .sync_found(sync_found), .resync_req(resync_req), .dens_off(dens_off),
    .rd_addr(rd_addr), .rd_data(rd_data), .all_ones(all_ones), .all_zeros(all_zeros),
    .in_sync(in_sync), .los(los));

  // behavioural reference
  bit q[$];
  int m_ones = 0, m_zeros = 0, m_blk = 0, m_errs = 0;
  bit m_sync = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ones = 0; m_zeros = 0; m_blk = 0; m_errs = 0; m_sync = 0;
    end else begin
      if (bit_en) begin
        q.push_back(rx_bit);
        if (q.size() > 32) void'(q.pop_front());
        if (rx_bit) begin m_ones = (m_ones < 32) ? m_ones + 1 : 32; m_zeros = 0; end
        else begin m_zeros = (m_zeros < 32) ? m_zeros + 1 : 32; m_ones = 0; end
      end
      if (!m_sync) begin
        if (sync_found) begin m_sync = 1; m_blk = 0; m_errs = 0; end
      end else if (resync_req) m_sync = 0;
      else if (bit_en) begin
        m_errs += bit_err;
        if (m_errs >= 6 && !dens_off) m_sync = 0;
        else if (m_blk == 63) begin m_blk = 0; m_errs = 0; end
        else m_blk++;
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [31:0] p = '0;
    for (int i = 0; i < q.size() && i < 32; i++) p[i] = q[q.size()-1-i];
    if (a >= 8'h10 && a <= 8'h13) return p[31-8*(a-8'h10) -: 8];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(all_ones  == (m_ones == 32),  "R1/R2 all_ones",  all_ones,  m_ones == 32);
    chk(all_zeros == (m_zeros == 32), "R3/R4 all_zeros", all_zeros, m_zeros == 32);
    chk(in_sync == m_sync, "R5/R6/R7/R8 in_sync", in_sync, m_sync);
    chk(los == !m_sync, "R5 los", los, !m_sync);
    chk(rd_data == exp_rd(rd_addr), "R9 rd_data", rd_data, exp_rd(rd_addr));
  end

  task automatic drive(input bit en, input bit b, input bit e);
    @(posedge clk); #1;
    bit_en = en; rx_bit = b; bit_err = e; sync_found = 0; resync_req = 0;
  endtask
  task automatic settle();
    drive(0, 0, 0);
    @(negedge clk);
  endtask
  task automatic acquire();
    @(posedge clk); #1; bit_en = 0; sync_found = 1; resync_req = 0;
    settle();
  endtask

  initial begin
    #400000;
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!in_sync && los && !all_ones && !all_zeros && rd_data == 0, "R5 reset state", in_sync, 0);

    // R1/R2: ones run
    for (int i = 0; i < 31; i++) drive(1, 1, 0);
    settle(); chk(!all_ones, "R1 31 ones", all_ones, 0);
    drive(1, 1, 0); settle(); chk(all_ones, "R1 32 ones", all_ones, 1);
    rd_addr = 8'h13; #0.1 chk(rd_data == 8'hFF, "R9 low byte ones", rd_data, 8'hFF);
    drive(1, 0, 0); settle(); chk(!all_ones, "R2 first zero", all_ones, 0);

    // R3/R4: zeros run
    for (int i = 0; i < 40; i++) drive(1, 0, 0);
    settle(); chk(all_zeros, "R3 zeros run", all_zeros, 1);
    // R10: disabled cycles do nothing
    for (int i = 0; i < 10; i++) drive(0, 1, 1);
    settle(); chk(all_zeros && rd_data == 8'h00, "R10 idle bits ignored", all_zeros, 1);
    drive(1, 1, 0); settle(); chk(!all_zeros, "R4 first one", all_zeros, 0);
    rd_addr = 8'h13; #0.1 chk(rd_data == 8'h01, "R9 newest bit at bit 0", rd_data, 1);
    rd_addr = 8'h14; #0.1 chk(rd_data == 8'h00, "R9 outside window", rd_data, 0);

    // R5: acquire
    acquire(); chk(in_sync && !los, "R5 acquire", in_sync, 1);

    // R6: 5 errors in block then boundary then 5 more: keep sync
    for (int i = 0; i < 64; i++) drive(1, i[0], i < 5);
    for (int i = 0; i < 5; i++) drive(1, 1, 1);
    settle(); chk(in_sync, "R6 block boundary restarts count", in_sync, 1);
    drive(1, 0, 1); settle(); chk(!in_sync, "R6 sixth error drops", in_sync, 0);
    chk(los, "R5 los during search", los, 1);

    // R7: density rule disabled
    dens_off = 1; acquire();
    for (int i = 0; i < 30; i++) drive(1, 1, 1);
    settle(); chk(in_sync, "R7 dens_off holds sync", in_sync, 1);
    // R8: resync
    @(posedge clk); #1 resync_req = 1; settle();
    chk(!in_sync, "R8 resync drops", in_sync, 0);
    dens_off = 0;

    // random phase
    for (int c = 0; c < 6000; c++) begin
      bit run_val = c[7];
      @(posedge clk); #1;
      bit_en     = ($urandom_range(0, 9) != 0);
      rx_bit     = ($urandom_range(0, 15) == 0) ? !run_val : run_val;
      if (c[8]) rx_bit = $urandom_range(0, 1);
      bit_err    = ($urandom_range(0, 11) == 0);
      sync_found = ($urandom_range(0, 20) == 0);
      resync_req = ($urandom_range(0, 400) == 0);
      if ($urandom_range(0, 300) == 0) dens_off = !dens_off;
      rd_addr    = 8'h0E + 8'($urandom_range(0, 7));
    end
    settle();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule